// File: doc/BRIEF.md
# One-hot basic-block sequencer

This block is the control half of a hardware function built from a small, fixed graph of basic blocks. It holds one state bit per basic block, with at most one bit set at a time. A single start pulse enters the graph at its entry block. From then on, control moves along the graph's arcs. It leaves a block when that block is active, every memory-completion flag the block waits on is high, and, where the block ends in a two-way branch, the branch condition points the right way. The datapath and the bus engines sit beside it. They read `state_o` to know which block is running, and they feed back the per-block branch conditions and the completion flags.

The graph is set entirely by parameters. Each block may have up to two predecessors. Each block may end in a two-way branch with a named taken successor. Each block selects, through a mask, the completion inputs it must see before it may be left. The block registers the vector of block-entry terms one cycle late on `launch_q_o`, so that neighbouring engines can start their work one cycle after a block is entered. It reports completion combinationally on `end_o`, which also returns the sequencer to idle.

Top module: `bb_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `state_o` and `launch_q_o` are all zeros and `end_o` is low.
- R2: `state_o` bit i stands for block i and is never more than one-hot. From idle, `start_i` high before a clock edge makes `state_o` equal to the entry block's bit after that edge (with default parameters, bit 0, value 6'b000001).
- R3: A block is entered from an active predecessor only if every `dep_done_i` bit selected by the predecessor's mask is high. Otherwise, when no entry term is true, `state_o` holds its value and `launch_q_o` reads zero after the edge.
- R4: When a predecessor ends in a two-way branch, its successor marked as taken is entered only with that predecessor's `cond_i` bit at 1, and its other successor only with the bit at 0.
- R5: A block with two predecessors is entered from either of them, each arc gated as in R3 and R4.
- R6: When several entry terms are true at once, only the lowest-indexed block is loaded into `state_o`.
- R7: `end_o` is high, without a clock edge, exactly when the final block is active, all of its selected completion flags are high, and, if it branches back into the graph, its `cond_i` bit is 0.
- R8: After an edge at which `end_o` was high, `state_o` and `launch_q_o` are all zeros, whatever entry terms were true.
- R9: `launch_q_o` shows, one cycle late, the full vector of entry terms (bit i is block i's term), unless `end_o` was high.
- R10: `end_o` stays low while `state_o` is zero, including the cycle in which `start_i` is first held high.
- R11: The default graph has six blocks. Block 0 is the entry and leads to 1. Block 1 branches on `cond_i[1]`: 1 goes to block 2 and 0 goes to block 4. Block 2 goes to 3 once `dep_done_i[0]` is high. Block 3 waits for `dep_done_i[2]` and branches on `cond_i[3]`: 1 goes back to block 1 and 0 goes to block 5. Block 4 goes to 5. Block 5 is final, waits for `dep_done_i[1]`, and returns to block 4 when `cond_i[5]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enters the graph at its entry block |
| cond_i | input | NUM_BLK | Branch condition, one bit per block |
| dep_done_i | input | NUM_DEP | Memory-completion flags |
| state_o | output | NUM_BLK | Zero-or-one-hot active block |
| launch_q_o | output | NUM_BLK | Entry-term vector, registered |
| end_o | output | 1 | Function complete (combinational) |

## Verification
A corrupted state vector shows up on `state_o` at the next edge, either as two bits set or as a bit moved to a block that no arc leads to. Errors in arc gating or branch polarity show up one edge later, as a wrong block or a state that fails to hold while a flag is low. The registered entry vector exposes the full set of competing terms, so a wrong priority choice becomes visible on the same edge as the wrong state. Completion faults are visible in the same cycle on `end_o`, and a missed clear shows on both vectors one edge after `end_o` rises.

// File: rtl/bbseq_pkg.sv
package bbseq_pkg;

   localparam int MAX_BLK = 16;
   localparam int IDX_W   = 4;
   localparam int ARC_W   = IDX_W + 1;   // {valid, source index}

   typedef enum logic [1:0] {
      POL_NONE = 2'd0,   // single successor, no condition
      POL_HIGH = 2'd1,   // condition must be 1
      POL_LOW  = 2'd2    // condition must be 0
   } arc_pol_e;

   function automatic bit arc_valid(input logic [MAX_BLK*ARC_W-1:0] tbl, input int blk);
      return tbl[blk*ARC_W + IDX_W];
   endfunction

   function automatic int arc_src(input logic [MAX_BLK*ARC_W-1:0] tbl, input int blk);
      return int'(tbl[blk*ARC_W +: IDX_W]);
   endfunction

endpackage

// File: rtl/bb_arc_term.sv
module bb_arc_term
   import bbseq_pkg::*;
#(
   parameter int                 NUM_DEP = 3,
   parameter arc_pol_e           POL     = POL_NONE,
   parameter logic [NUM_DEP-1:0] DMASK   = '0
) (
   input  logic               src_act_i,
   input  logic               src_cond_i,
   input  logic [NUM_DEP-1:0] dep_done_i,
   output logic               fire_o
);

   logic deps_ok;
   logic pol_ok;

   // every selected completion flag must be high
   assign deps_ok = &(dep_done_i | ~DMASK);

   always_comb begin
      unique case (POL)
         POL_HIGH: pol_ok = src_cond_i;
         POL_LOW:  pol_ok = ~src_cond_i;
         default:  pol_ok = 1'b1;
      endcase
   end

   assign fire_o = src_act_i & deps_ok & pol_ok;

endmodule

// File: rtl/bb_onehot_state.sv
module bb_onehot_state #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic [N-1:0] start_vec_i,
   output logic [N-1:0] state_o,
   output logic [N-1:0] launch_q_o
);

   logic [N-1:0] pick;
   logic         load;

   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (start_vec_i[i]) pick = N'(1) << i;
      end
   end

   assign load = |start_vec_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o    <= '0;
         launch_q_o <= '0;
      end else if (clear_i) begin
         state_o    <= '0;
         launch_q_o <= '0;
      end else begin
         if (load) state_o <= pick;
         launch_q_o <= start_vec_i;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (state_o == '0 && launch_q_o == '0)); // R1
   AST_STATE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(state_o)); // R2
   AST_NO_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && start_vec_i == '0) |=> $stable(state_o)); // R3
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && |start_vec_i) |=> state_o == $past(start_vec_i & (~start_vec_i + 1'b1))); // R6
   AST_CLEAR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (state_o == '0 && launch_q_o == '0)); // R8
   AST_LAUNCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> launch_q_o == $past(start_vec_i)); // R9

endmodule

// File: rtl/bb_end_detect.sv
module bb_end_detect #(
   parameter int                 NUM_DEP = 3,
   parameter bit                 LOOPS   = 1'b1,
   parameter logic [NUM_DEP-1:0] DMASK   = '0
) (
   input  logic               final_act_i,
   input  logic               final_cond_i,
   input  logic [NUM_DEP-1:0] dep_done_i,
   output logic               end_o
);

   logic deps_ok;
   logic exit_ok;

   assign deps_ok = &(dep_done_i | ~DMASK);
   // a looping final block exits only on the not-taken path
   assign exit_ok = LOOPS ? ~final_cond_i : 1'b1;
   assign end_o   = final_act_i & deps_ok & exit_ok;

endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
   import bbseq_pkg::*;
#(
   parameter int                         NUM_BLK   = 6,
   parameter int                         NUM_DEP   = 3,
   parameter int                         FINAL_BLK = 5,
   parameter logic [MAX_BLK*ARC_W-1:0]   PRED_A    = {{10{5'h00}}, 5'h14, 5'h11, 5'h12, 5'h11, 5'h10, 5'h00},
   parameter logic [MAX_BLK*ARC_W-1:0]   PRED_B    = {{10{5'h00}}, 5'h13, 5'h15, 5'h00, 5'h00, 5'h13, 5'h00},
   parameter logic [MAX_BLK-1:0]         TWO_WAY   = 16'h002A,
   parameter logic [MAX_BLK*IDX_W-1:0]   TAKEN     = {{10{4'h0}}, 4'h4, 4'h0, 4'h1, 4'h0, 4'h2, 4'h0},
   parameter logic [MAX_BLK*NUM_DEP-1:0] DEP_MASK  = {{10{3'b000}}, 3'b010, 3'b000, 3'b100, 3'b001, 3'b000, 3'b000}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [NUM_BLK-1:0] cond_i,
   input  logic [NUM_DEP-1:0] dep_done_i,
   output logic [NUM_BLK-1:0] state_o,
   output logic [NUM_BLK-1:0] launch_q_o,
   output logic               end_o
);

   localparam logic [NUM_DEP-1:0] FINAL_MASK = DEP_MASK[FINAL_BLK*NUM_DEP +: NUM_DEP];
   localparam bit                 FINAL_LOOP = TWO_WAY[FINAL_BLK];

   // elaboration-time parameter checks
   if (NUM_BLK < 1 || NUM_BLK > MAX_BLK) begin : g_bad_count
      $error("bb_sequencer: NUM_BLK must lie in 1..16");
   end
   if (NUM_DEP < 1) begin : g_bad_dep
      $error("bb_sequencer: NUM_DEP must be at least 1");
   end
   if (FINAL_BLK < 0 || FINAL_BLK >= NUM_BLK) begin : g_bad_final
      $error("bb_sequencer: FINAL_BLK out of range");
   end

   logic [NUM_BLK-1:0] start_vec;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      localparam bit       HAS_A = arc_valid(PRED_A, b);
      localparam bit       HAS_B = arc_valid(PRED_B, b);
      localparam int       SRC_A = arc_src(PRED_A, b);
      localparam int       SRC_B = arc_src(PRED_B, b);
      localparam arc_pol_e POL_A = !TWO_WAY[SRC_A] ? POL_NONE :
         ((int'(TAKEN[SRC_A*IDX_W +: IDX_W]) == b) ? POL_HIGH : POL_LOW);
      localparam arc_pol_e POL_B = !TWO_WAY[SRC_B] ? POL_NONE :
         ((int'(TAKEN[SRC_B*IDX_W +: IDX_W]) == b) ? POL_HIGH : POL_LOW);

      if (HAS_A && SRC_A >= NUM_BLK) begin : g_bad_a
         $error("bb_sequencer: first predecessor index out of range");
      end
      if (HAS_B && SRC_B >= NUM_BLK) begin : g_bad_b
         $error("bb_sequencer: second predecessor index out of range");
      end

      if (HAS_A) begin : g_arcs
         logic fire_a;
         logic fire_b;

         bb_arc_term #(
            .NUM_DEP (NUM_DEP),
            .POL     (POL_A),
            .DMASK   (DEP_MASK[SRC_A*NUM_DEP +: NUM_DEP])
         ) u_arc_a (
            .src_act_i  (state_o[SRC_A]),
            .src_cond_i (cond_i[SRC_A]),
            .dep_done_i (dep_done_i),
            .fire_o     (fire_a)
         );

         if (HAS_B) begin : g_second
            bb_arc_term #(
               .NUM_DEP (NUM_DEP),
               .POL     (POL_B),
               .DMASK   (DEP_MASK[SRC_B*NUM_DEP +: NUM_DEP])
            ) u_arc_b (
               .src_act_i  (state_o[SRC_B]),
               .src_cond_i (cond_i[SRC_B]),
               .dep_done_i (dep_done_i),
               .fire_o     (fire_b)
            );
         end else begin : g_single
            assign fire_b = 1'b0;
         end

         assign start_vec[b] = fire_a | fire_b;
      end else begin : g_entry
         assign start_vec[b] = start_i;
      end
   end

   bb_onehot_state #(
      .N (NUM_BLK)
   ) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (end_o),
      .start_vec_i (start_vec),
      .state_o     (state_o),
      .launch_q_o  (launch_q_o)
   );

   bb_end_detect #(
      .NUM_DEP (NUM_DEP),
      .LOOPS   (FINAL_LOOP),
      .DMASK   (FINAL_MASK)
   ) u_end (
      .final_act_i  (state_o[FINAL_BLK]),
      .final_cond_i (cond_i[FINAL_BLK]),
      .dep_done_i   (dep_done_i),
      .end_o        (end_o)
   );

   AST_IDLE_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == '0) |-> !end_o); // R10
   AST_END_NEEDS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |-> (state_o[FINAL_BLK] && $onehot(state_o))); // R7

endmodule

// File: tb/test_bb_sequencer.sv
module test_bb_sequencer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [5:0] cond_i = '0;
   logic [2:0] dep_done_i = '0;
   logic [5:0] state_o;
   logic [5:0] launch_q_o;
   logic       end_o;

   int n_checks = 0;
   int n_fails  = 0;

   logic [12:0] exp_q[$];   // {state, launch, end} after the edge
   string       tag_q[$];

   always #4 clk = ~clk;    // 125 MHz

   bb_sequencer i_bb_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cond_i     (cond_i),
      .dep_done_i (dep_done_i),
      .state_o    (state_o),
      .launch_q_o (launch_q_o),
      .end_o      (end_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   // driver: apply inputs, check end_o before the edge, queue the post-edge view
   task automatic step(input logic st, input logic [5:0] c, input logic [2:0] d,
                       input logic pre_end, input logic [5:0] xs, input logic [5:0] xl,
                       input logic xe, input string tag);
      @(negedge clk);
      start_i    = st;
      cond_i     = c;
      dep_done_i = d;
      #1;
      chk(tag, "end_o before edge", 32'(end_o), 32'(pre_end));
      exp_q.push_back({xs, xl, xe});
      tag_q.push_back(tag);
      @(posedge clk);
   endtask

   // monitor: compare what the design shows just after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [12:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "state_o", 32'(state_o), 32'(e[12:7]));
            chk(t, "launch_q_o", 32'(launch_q_o), 32'(e[6:1]));
            chk(t, "end_o", 32'(end_o), 32'(e[0]));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "state_o in reset", 32'(state_o), 32'h0);
      chk("R1", "launch_q_o in reset", 32'(launch_q_o), 32'h0);
      chk("R1", "end_o in reset", 32'(end_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "state_o after reset", 32'(state_o), 32'h0);
      chk("R1", "launch_q_o after reset", 32'(launch_q_o), 32'h0);

      // R11 default graph; cond bit1/3/5, deps bit0/1/2
      step(1, 6'b000000, 3'b000, 0, 6'b000001, 6'b000001, 0, "R2 R10 entry");
      step(0, 6'b000010, 3'b000, 0, 6'b000010, 6'b000010, 0, "R9 b0 to b1");
      step(0, 6'b000010, 3'b000, 0, 6'b000100, 6'b000100, 0, "R4 taken b1 to b2");
      step(0, 6'b000000, 3'b000, 0, 6'b000100, 6'b000000, 0, "R3 hold b2 dep low");
      step(0, 6'b000000, 3'b001, 0, 6'b001000, 6'b001000, 0, "R3 b2 to b3 dep done");
      step(0, 6'b001000, 3'b000, 0, 6'b001000, 6'b000000, 0, "R3 hold b3 dep low");
      step(0, 6'b001000, 3'b100, 0, 6'b000010, 6'b000010, 0, "R5 b3 back to b1");
      step(0, 6'b000000, 3'b000, 0, 6'b010000, 6'b010000, 0, "R4 not taken b1 to b4");
      step(0, 6'b000000, 3'b000, 0, 6'b100000, 6'b100000, 0, "R7 b5 dep low no end");
      step(0, 6'b100000, 3'b010, 0, 6'b010000, 6'b010000, 0, "R5 R7 b5 loops to b4");
      step(0, 6'b000000, 3'b010, 0, 6'b100000, 6'b100000, 1, "R7 end raised");
      step(1, 6'b000000, 3'b010, 1, 6'b000000, 6'b000000, 0, "R8 end clears");
      step(1, 6'b000000, 3'b000, 0, 6'b000001, 6'b000001, 0, "R2 restart");
      step(0, 6'b000010, 3'b000, 0, 6'b000010, 6'b000010, 0, "R2 b0 to b1");
      step(1, 6'b000010, 3'b000, 0, 6'b000001, 6'b000101, 0, "R6 R9 lowest wins");
      step(0, 6'b000010, 3'b000, 0, 6'b000010, 6'b000010, 0, "R6 b0 to b1");
      step(0, 6'b000010, 3'b000, 0, 6'b000100, 6'b000100, 0, "R4 b1 to b2");
      step(0, 6'b000000, 3'b001, 0, 6'b001000, 6'b001000, 0, "R3 b2 to b3");
      step(0, 6'b000000, 3'b100, 0, 6'b100000, 6'b100000, 0, "R4 b3 not taken to b5");
      step(0, 6'b000000, 3'b000, 0, 6'b100000, 6'b000000, 0, "R7 hold b5 dep low");
      step(0, 6'b000000, 3'b010, 1, 6'b000000, 6'b000000, 0, "R8 second end");

      repeat (2) @(posedge clk);
      #3;
      summary();
      $finish;
   end

endmodule